// File: doc/BRIEF.md
# Skip-Mask Instruction Sequencer

This block sits between instruction fetch and issue and decides, slot by slot, whether each issued instruction runs or is suppressed. A 32-bit word arms it. That word comes either from a pure skip instruction, where the whole word is the skip pattern, or from a combined jump-and-skip instruction. In the combined form, the low ten bits are a local target address in the range $000..$3FF and the remaining upper bits are the skip pattern. The combined instruction raises a jump request in the same cycle. When its pattern bits are all zero it acts as a plain jump and arms nothing. A common use is a 256-entry table of jump/skip words held in half of the local lookup memory, one entry per bytecode.

The pattern is consumed from its LSB, one bit per valid issue slot. A 1 means the instruction in that slot is skipped. In normal mode a skipped instruction still takes its slot, as a side-effect-free NOP. In fast mode the sequencer tells fetch to step past a run of skipped instructions, so the next executing instruction issues at once. A run of eight consecutive skips costs one NOP cycle. When the shared-memory execution domain is active, fast mode behaves exactly like normal mode.

The controller has three states: `ST_IDLE` (nothing armed), `ST_NORM` (normal skipping) and `ST_FAST` (fast skipping). Its transitions are:
- ARM: from any state, a load with a nonzero pattern goes to `ST_NORM` or `ST_FAST`.
- FLUSH: a taken branch goes to `ST_IDLE`.
- DRAIN: a consumed slot that leaves the pattern empty goes to `ST_IDLE`.
- HOLD: in all other cases the state stays as it is.

Top module: `skip_sequencer`

## Requirements
- R1: After reset, `skip_active` is 0, and every valid slot executes with `fetch_step` = 1.
- R2: After a skip-only load (`load_jump`=0) in normal mode, slot n (counting only cycles with `slot_valid`=1, from 0) shows `issue_nop`=1 if bit n of the loaded word is 1, and otherwise `issue_exec`=1. In both cases `fetch_step` = 1.
- R3: A load with `load_jump`=1 raises `jump_valid` in the same cycle, with `jump_addr` = `load_word[9:0]`. Bits [31:10] become the skip pattern, and slot 0 uses bit 10.
- R4: A jump load whose bits [31:10] are zero leaves `skip_active` at 0.
- R5: In fast mode outside the shared domain, a run of k ones (1 ≤ k ≤ 7) at the pattern head is bypassed. The slot executes with `fetch_step` = k+1, and k+1 bits are consumed.
- R6: In fast mode outside the shared domain, when the pattern head holds 8 or more ones, the slot is a NOP with `fetch_step` = 8, and 8 bits are consumed.
- R7: While `domain_shared`=1, a fast-mode pattern is consumed one bit per slot, as in R2.
- R8: Once every 1 bit of the pattern has been consumed, `skip_active` falls to 0 from the next cycle.
- R9: `branch_taken` without a load clears the pattern, so `skip_active` is 0 on the next cycle.
- R10: A load while a pattern is armed replaces it completely. Slot 0 then uses bit 0 of the new pattern.
- R11: A cycle with `slot_valid`=0 consumes no bits and gives `issue_exec`=0, `issue_nop`=0 and `fetch_step`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_valid | input | 1 | Arm with `load_word` this cycle |
| load_jump | input | 1 | 1: combined jump-and-skip form; 0: skip-only form |
| load_fast | input | 1 | 1: fast skipping; 0: normal skipping |
| load_word | input | 32 | Pattern, or target (low 10 bits) plus pattern |
| domain_shared | input | 1 | Executing from shared memory |
| slot_valid | input | 1 | An instruction occupies the issue slot |
| branch_taken | input | 1 | A taken branch this cycle |
| jump_valid | output | 1 | Jump request of a combined load |
| jump_addr | output | 10 | Local jump target |
| issue_exec | output | 1 | Slot instruction executes |
| issue_nop | output | 1 | Slot spent as NOP |
| fetch_step | output | 4 | Instructions fetch advances past this slot |
| skip_active | output | 1 | A pattern is armed |

## Verification
A wrong pattern or state shows up in the first valid slot after the load: execute and NOP swap, or `fetch_step` takes a different value. In fast mode, a wrong run count shows up at once as a different step. A pattern left armed when it should have cleared keeps `skip_active` high one cycle after the drain or flush that should have ended it. A mask that shifts during empty slots shows as a NOP landing on the wrong later slot.

// File: rtl/sks_pkg.sv
package sks_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NORM = 2'd1,
        ST_FAST = 2'd2
    } sks_state_e;
endpackage

// File: rtl/sks_run_len.sv
module sks_run_len #(
    parameter int IN_W  = 32,
    parameter int MAX   = 8,
    parameter int CNT_W = 4
) (
    input  logic [IN_W-1:0]  bits_i,
    output logic [CNT_W-1:0] run_o
);
    always_comb begin
        logic stop;
        stop  = 1'b0;
        run_o = '0;
        for (int i = 0; i < MAX; i++) begin
            if (!stop && bits_i[i]) run_o = run_o + CNT_W'(1);
            else stop = 1'b1;
        end
    end
endmodule

// File: rtl/sks_mask_shift.sv
module sks_mask_shift #(
    parameter int W     = 32,
    parameter int AMT_W = 4
) (
    input  logic [W-1:0]     mask_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [W-1:0]     mask_o,
    output logic             empty_o
);
    assign mask_o  = mask_i >> amt_i;
    assign empty_o = (mask_o == '0);
endmodule

// File: rtl/skip_sequencer.sv
module skip_sequencer #(
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 10,
    parameter int FAST_RUN = 8,
    parameter int STEP_W   = $clog2(FAST_RUN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic              load_jump,
    input  logic              load_fast,
    input  logic [WORD_W-1:0] load_word,
    input  logic              domain_shared,
    input  logic              slot_valid,
    input  logic              branch_taken,
    output logic              jump_valid,
    output logic [ADDR_W-1:0] jump_addr,
    output logic              issue_exec,
    output logic              issue_nop,
    output logic [STEP_W-1:0] fetch_step,
    output logic              skip_active
);
    import sks_pkg::*;

    localparam logic [STEP_W-1:0] ONE_STEP = STEP_W'(1);
    localparam logic [STEP_W-1:0] RUN_CAP  = STEP_W'(FAST_RUN);

    sks_state_e          state_q, state_d;
    logic [WORD_W-1:0]   mask_q, mask_d;
    logic [WORD_W-1:0]   load_pat, mask_sh;
    logic [STEP_W-1:0]   run_len, shamt;
    logic                sh_empty, fast_eff;

    assign load_pat = load_jump ? (load_word >> ADDR_W) : load_word;
    assign fast_eff = (state_q == ST_FAST) && !domain_shared;

    sks_run_len #(.IN_W(WORD_W), .MAX(FAST_RUN), .CNT_W(STEP_W)) u_run (
        .bits_i (mask_q),
        .run_o  (run_len)
    );

    always_comb begin
        if (!fast_eff)               shamt = ONE_STEP;
        else if (run_len == RUN_CAP) shamt = RUN_CAP;
        else                         shamt = run_len + ONE_STEP;
    end

    sks_mask_shift #(.W(WORD_W), .AMT_W(STEP_W)) u_shift (
        .mask_i  (mask_q),
        .amt_i   (shamt),
        .mask_o  (mask_sh),
        .empty_o (sh_empty)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
        end
    end

    // transitions: ARM, FLUSH, DRAIN, HOLD
    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        if (load_valid) begin
            mask_d = load_pat;
            if (load_pat == '0)  state_d = ST_IDLE;
            else if (load_fast)  state_d = ST_FAST;
            else                 state_d = ST_NORM;
        end else if (branch_taken) begin
            state_d = ST_IDLE;
            mask_d  = '0;
        end else if (slot_valid) begin
            unique case (state_q)
                ST_IDLE: ;
                ST_NORM, ST_FAST: begin
                    mask_d = mask_sh;
                    if (sh_empty) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        issue_exec = 1'b0;
        issue_nop  = 1'b0;
        fetch_step = '0;
        if (slot_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    issue_exec = 1'b1;
                    fetch_step = ONE_STEP;
                end
                ST_NORM, ST_FAST: begin
                    fetch_step = shamt;
                    if (fast_eff) begin
                        issue_nop  = (run_len == RUN_CAP);
                        issue_exec = (run_len != RUN_CAP);
                    end else begin
                        issue_nop  = mask_q[0];
                        issue_exec = !mask_q[0];
                    end
                end
                default: ;
            endcase
        end
    end

    assign jump_valid  = load_valid && load_jump;
    assign jump_addr   = load_word[ADDR_W-1:0];
    assign skip_active = (state_q != ST_IDLE);
endmodule

// File: rtl/sks_chk.sv
module sks_chk #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 10,
    parameter int STEP_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_valid,
    input logic              load_jump,
    input logic [WORD_W-1:0] load_word,
    input logic              domain_shared,
    input logic              slot_valid,
    input logic              branch_taken,
    input logic              issue_exec,
    input logic              issue_nop,
    input logic [STEP_W-1:0] fetch_step,
    input logic              skip_active
);
    // R2
    exec_nop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_exec && issue_nop));
    // R1
    idle_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!skip_active && slot_valid) |-> (issue_exec && fetch_step == STEP_W'(1)));
    // R4
    plain_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && load_jump && (load_word >> ADDR_W) == '0) |=> !skip_active);
    // R9
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_taken && !load_valid) |=> !skip_active);
    // R7
    shared_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (domain_shared && slot_valid) |-> fetch_step == STEP_W'(1));
    // R5
    bypass_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_step > STEP_W'(1) && !issue_nop) |-> (issue_exec && !domain_shared));
    // R11
    empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_valid |-> (!issue_exec && !issue_nop && fetch_step == '0));
endmodule

bind skip_sequencer sks_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_jump(load_jump),
    .load_word(load_word), .domain_shared(domain_shared), .slot_valid(slot_valid),
    .branch_taken(branch_taken), .issue_exec(issue_exec), .issue_nop(issue_nop),
    .fetch_step(fetch_step), .skip_active(skip_active)
);

// File: tb/sim_skip_sequencer.sv
`timescale 1ns/1ps
module sim_skip_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0, load_jump = 1'b0, load_fast = 1'b0;
    logic [31:0] load_word = '0;
    logic        domain_shared = 1'b0, slot_valid = 1'b0, branch_taken = 1'b0;
    logic        jump_valid, issue_exec, issue_nop, skip_active;
    logic [9:0]  jump_addr;
    logic [3:0]  fetch_step;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    skip_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_jump(load_jump),
        .load_fast(load_fast), .load_word(load_word), .domain_shared(domain_shared),
        .slot_valid(slot_valid), .branch_taken(branch_taken), .jump_valid(jump_valid),
        .jump_addr(jump_addr), .issue_exec(issue_exec), .issue_nop(issue_nop),
        .fetch_step(fetch_step), .skip_active(skip_active)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(bit jmp, bit fast, logic [31:0] w);
        load_valid = 1'b1; load_jump = jmp; load_fast = fast; load_word = w;
        #1;
        @(posedge clk); #1;
        load_valid = 1'b0; load_jump = 1'b0; load_fast = 1'b0;
    endtask

    // one valid slot: expect {exec, nop, step}
    task automatic slot(string req, bit ex, bit nop, int step);
        slot_valid = 1'b1;
        #1;
        check(req, {issue_exec, issue_nop, fetch_step}, {ex, nop, 4'(step)});
        @(posedge clk); #1;
        slot_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 active", skip_active, 0);
        slot("R1 idle slot", 1, 0, 1);
    endtask

    task automatic t_normal;
        load(0, 0, 32'b0101);
        check("R2 armed", skip_active, 1);
        slot("R2 s0", 0, 1, 1);
        slot("R2 s1", 1, 0, 1);
        slot("R2 s2", 0, 1, 1);
        check("R8 drained", skip_active, 0);
    endtask

    task automatic t_jump;
        load_valid = 1'b1; load_jump = 1'b1; load_word = (32'b101 << 10) | 32'h155;
        #1;
        check("R3 jump", {jump_valid, jump_addr}, {1'b1, 10'h155});
        @(posedge clk); #1;
        load_valid = 1'b0; load_jump = 1'b0;
        slot("R3 s0", 0, 1, 1);
        slot("R3 s1", 1, 0, 1);
        slot("R3 s2", 0, 1, 1);
        check("R8 jump drained", skip_active, 0);
        load(1, 0, 32'h2AA);
        check("R4 plain jump", skip_active, 0);
    endtask

    task automatic t_fast;
        load(0, 1, 32'b0111);
        slot("R5 run3", 1, 0, 4);
        check("R8 fast drained", skip_active, 0);
        load(0, 1, 32'h3FF);
        slot("R6 run8", 0, 1, 8);
        slot("R5 run2", 1, 0, 3);
        check("R8 idle", skip_active, 0);
    endtask

    task automatic t_shared;
        domain_shared = 1'b1;
        load(0, 1, 32'b0111);
        slot("R7 s0", 0, 1, 1);
        slot("R7 s1", 0, 1, 1);
        slot("R7 s2", 0, 1, 1);
        check("R7 drained", skip_active, 0);
        domain_shared = 1'b0;
    endtask

    task automatic t_branch;
        load(0, 0, 32'hFF);
        slot("R9 pre", 0, 1, 1);
        branch_taken = 1'b1; slot_valid = 1'b1;
        @(posedge clk); #1;
        branch_taken = 1'b0; slot_valid = 1'b0;
        check("R9 flushed", skip_active, 0);
        slot("R9 after", 1, 0, 1);
    endtask

    task automatic t_reload;
        load(0, 0, 32'b01);
        load(0, 0, 32'b10);
        slot("R10 s0", 1, 0, 1);
        slot("R10 s1", 0, 1, 1);
        check("R10 drained", skip_active, 0);
    endtask

    task automatic t_noslot;
        load(0, 0, 32'b1);
        for (int i = 0; i < 3; i++) begin
            check("R11 quiet", {issue_exec, issue_nop, fetch_step}, 6'd0);
            @(posedge clk); #1;
        end
        check("R11 held", skip_active, 1);
        slot("R11 nop", 0, 1, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_normal();
        t_jump();
        t_fast();
        t_shared();
        t_branch();
        t_reload();
        t_noslot();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule